// File: doc/BRIEF.md
# Card Data Block Receiver

This block pulls one data block from a memory card on a byte-exchange SPI port once a read command has been accepted. Each exchange it issues sends the filler value 0xFF and returns one byte from the card. It first hunts for the start token with a bounded poll. It then forwards the payload bytes, each with its index, on a valid/ready stream. It reads and throws away the two trailing CRC bytes. Finally it pulses `done` and gives a status code: 0 for success, 1 for timeout, 2 for a bad token.

A transfer begins when `start` is pulsed while the block is idle. The block captures `blk_len` (at most `MAX_LEN`, 512 by default) and `zero_first` at that point. When `zero_first` is set, the block emits a 0x00 byte at index 0 without reading it from the card. It then takes only `blk_len - 1` bytes from the card and places them at indices 1 onward.

Back-pressure rules: `out_valid` stays high with `out_data` and `out_idx` unchanged until `out_ready` is seen high at a clock edge. While a byte is waiting on the stream, no new exchange is requested, so the card is never read faster than the consumer drains. The exchange port follows the same rules. `xchg_valid` holds until `xchg_ready`. Exactly one exchange is outstanding at a time, and its reply arrives as a single-cycle `rsp_valid` some cycles later.

Top module: `blk_rx_top`

## Requirements
- R1: After reset, `busy`, `done`, `xchg_valid` and `out_valid` are low.
- R2: Every accepted exchange carries `xchg_tx` = 0xFF.
- R3: While hunting, each 0xFF reply triggers another exchange, for up to `POLL_LIMIT` (20000) exchanges. A token arriving as the 20000th reply is still accepted.
- R4: If `POLL_LIMIT` consecutive replies are all 0xFF, `done` pulses with status 1 (timeout). No payload byte is emitted, and exactly `POLL_LIMIT` exchanges are made.
- R5: If the first non-0xFF reply is not 0xFE, `done` pulses with status 2 (bad token). No payload is emitted and no further exchange is made.
- R6: After token 0xFE, exactly `blk_len` bytes leave on the stream in card order, with `out_idx` running from 0 to `blk_len-1`.
- R7: After the payload, exactly two more exchanges are made and their replies are discarded. Then `done` pulses with status 0. The total number of exchanges is polls + 1 + payload reads + 2.
- R8: With `zero_first` set, index 0 carries 0x00. The card supplies `blk_len-1` bytes, which appear at indices 1 onward. With `blk_len` = 1, only the zero byte is emitted.
- R9: A start with `blk_len` = 0 pulses `done` with status 0 on the next cycle and makes no exchange.
- R10: `out_valid`, `out_data` and `out_idx` hold steady until accepted, and `xchg_valid` is low whenever `out_valid` is high.
- R11: `busy` is high from the cycle after a start with nonzero length until `done`, and low with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (idle only) |
| blk_len | input | LEN_W | Block length in bytes, 0..MAX_LEN |
| zero_first | input | 1 | Zero-first register-read mode |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 timeout, 2 bad token; held until next start |
| xchg_valid | output | 1 | Exchange request |
| xchg_ready | input | 1 | Exchange request accepted |
| xchg_tx | output | 8 | Byte sent on the exchange |
| rsp_valid | input | 1 | Reply byte strobe |
| rsp_data | input | 8 | Reply byte from card |
| out_valid | output | 1 | Payload byte available |
| out_ready | input | 1 | Consumer takes payload byte |
| out_data | output | 8 | Payload byte |
| out_idx | output | LEN_W | Index of payload byte in block |

## Verification
A wrong phase or a miscounted index shows up at the ports within one exchange. It appears as an extra or missing exchange, a byte at the wrong index, or a `done` with the wrong status. The poll counter can only be observed at its boundary. For that reason, the token arriving as the 20000th reply and the 20000-filler timeout are both driven, and the exchange totals are compared exactly. A stream stage that overwrote a pending byte, or that let an exchange start under back-pressure, would show in the first stalled cycle. Random stalls on both handshakes are applied to expose it.

// File: rtl/blk_rx_pkg.sv
package blk_rx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HUNT = 2'd1,
    PH_DATA = 2'd2,
    PH_TAIL = 2'd3
  } rx_phase_t;

  typedef enum logic [1:0] {
    RX_OK      = 2'd0,
    RX_TIMEOUT = 2'd1,
    RX_BADTOK  = 2'd2
  } rx_status_t;

  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [7:0] START_TOK  = 8'hFE;
endpackage

// File: rtl/blk_rx_poll_timer.sv
module blk_rx_poll_timer #(
  parameter int LIMIT = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign last = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (step && !last) cnt <= cnt + CW'(1);
  end

  // R3: the hunt never counts past its bound
  a_r3_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT));
endmodule

// File: rtl/blk_rx_out_stage.sv
module blk_rx_out_stage #(
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [7:0]    load_data,
  input  logic [IW-1:0] load_idx,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic [IW-1:0] out_idx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_idx   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
      out_idx   <= load_idx;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10: a stalled byte stays put
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_idx));
  // R10: a pending byte is never overwritten
  a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid);
endmodule

// File: rtl/blk_rx_top.sv
module blk_rx_top
  import blk_rx_pkg::*;
#(
  parameter int MAX_LEN    = 512,
  parameter int POLL_LIMIT = 20000,
  parameter int LEN_W      = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             zero_first,
  output logic             busy,
  output logic             done,
  output logic [1:0]       status,
  output logic             xchg_valid,
  input  logic             xchg_ready,
  output logic [7:0]       xchg_tx,
  input  logic             rsp_valid,
  input  logic [7:0]       rsp_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic [LEN_W-1:0] out_idx
);
  rx_phase_t        phase;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] idx;
  logic             zf_q;
  logic             wait_rsp;
  logic             tail_second;
  logic             poll_last;
  logic             got;
  logic             xchg_fire;
  logic             load;
  logic [7:0]       load_data;
  logic [LEN_W-1:0] load_idx;
  logic             hunt_fill;

  assign busy       = (phase != PH_IDLE);
  assign xchg_tx    = FILL_BYTE;
  assign xchg_valid = busy && !wait_rsp && !out_valid;
  assign xchg_fire  = xchg_valid && xchg_ready;
  assign got        = wait_rsp && rsp_valid;
  assign hunt_fill  = got && (phase == PH_HUNT) && (rsp_data == FILL_BYTE);

  // payload capture or the synthetic zero byte in register-read mode
  always_comb begin
    load      = 1'b0;
    load_data = rsp_data;
    load_idx  = idx;
    if (got && phase == PH_DATA) begin
      load = 1'b1;
    end else if (got && phase == PH_HUNT && rsp_data == START_TOK && zf_q) begin
      load      = 1'b1;
      load_data = 8'h00;
      load_idx  = '0;
    end
  end

  blk_rx_poll_timer #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!busy && start),
    .step (hunt_fill),
    .last (poll_last)
  );

  blk_rx_out_stage #(.IW(LEN_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_data(load_data),
    .load_idx (load_idx),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_idx  (out_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      len_q       <= '0;
      idx         <= '0;
      zf_q        <= 1'b0;
      wait_rsp    <= 1'b0;
      tail_second <= 1'b0;
      done        <= 1'b0;
      status      <= RX_OK;
    end else begin
      done <= 1'b0;
      if (xchg_fire) wait_rsp <= 1'b1;
      if (got)       wait_rsp <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            status      <= RX_OK;
            len_q       <= blk_len;
            zf_q        <= zero_first;
            idx         <= '0;
            wait_rsp    <= 1'b0;
            tail_second <= 1'b0;
            if (blk_len == '0) done  <= 1'b1;
            else               phase <= PH_HUNT;
          end
        end
        PH_HUNT: begin
          if (got) begin
            if (rsp_data == FILL_BYTE) begin
              if (poll_last) begin
                status <= RX_TIMEOUT;
                done   <= 1'b1;
                phase  <= PH_IDLE;
              end
            end else if (rsp_data == START_TOK) begin
              if (zf_q) begin
                idx   <= LEN_W'(1);
                phase <= (len_q == LEN_W'(1)) ? PH_TAIL : PH_DATA;
              end else begin
                idx   <= '0;
                phase <= PH_DATA;
              end
            end else begin
              status <= RX_BADTOK;
              done   <= 1'b1;
              phase  <= PH_IDLE;
            end
          end
        end
        PH_DATA: begin
          if (got) begin
            idx <= idx + LEN_W'(1);
            if (idx == len_q - LEN_W'(1)) phase <= PH_TAIL;
          end
        end
        PH_TAIL: begin
          if (got) begin
            if (tail_second) begin
              status <= RX_OK;
              done   <= 1'b1;
              phase  <= PH_IDLE;
            end else begin
              tail_second <= 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R9: empty block finishes on the next cycle
  a_r9_empty_len: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && blk_len == '0 |=> done && status == RX_OK && !busy);
  // R10: no exchange while a byte waits on the stream
  a_r10_xchg_gap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !xchg_valid);
  // R6: indices stay inside the block
  a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_idx < len_q);
  // R11: busy falls with done
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7: an exchange request is held until taken
  a_r7_xchg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_valid && !xchg_ready |=> xchg_valid);
  // R1: nothing happens in the cycle after reset
  a_r1_quiet: assert property (@(posedge clk)
    !$past(rst_n) |-> !busy && !done && !out_valid);
endmodule

// File: tb/tb_blk_rx_top.sv
module tb_blk_rx_top;
  localparam int LW = 10;
  localparam int LIMIT = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] blk_len = '0;
  logic          zero_first = 1'b0;
  logic          busy, done;
  logic [1:0]    status;
  logic          xchg_valid;
  logic          xchg_ready = 1'b0;
  logic [7:0]    xchg_tx;
  logic          rsp_valid = 1'b0;
  logic [7:0]    rsp_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [7:0]    out_data;
  logic [LW-1:0] out_idx;

  always #2.5 clk = ~clk;

  blk_rx_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_len(blk_len),
    .zero_first(zero_first), .busy(busy), .done(done), .status(status),
    .xchg_valid(xchg_valid), .xchg_ready(xchg_ready), .xchg_tx(xchg_tx),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_idx(out_idx)
  );

  int checks = 0, fails = 0;
  // card script and model state
  int m_nff = 0, m_len = 0, m_zf = 0, m_lat = 0, m_xrdy = 100, m_ordy = 100;
  int pay_base = 0;
  logic [7:0] m_tok = 8'hFE;
  int kbyte = 0, lat = 0, armed = 0;
  int xchg_cnt = 0, bad_tx = 0, out_cnt = 0, data_err = 0, hold_err = 0, gap_err = 0;
  int hold_pend = 0;
  logic [7:0] hd;
  logic [LW-1:0] hi;
  int done_seen = 0;
  logic [1:0] done_stat;
  int finished = 0;

  function automatic logic [7:0] pay(int i);
    return 8'((i * 37 + pay_base) & 255);
  endfunction

  function automatic int ncard();
    return (m_zf != 0) ? m_len - 1 : m_len;
  endfunction

  function automatic logic [7:0] card_byte(int k);
    if (k < m_nff) return 8'hFF;
    if (k == m_nff) return m_tok;
    if (k - m_nff - 1 < ncard()) return pay(k - m_nff - 1);
    if (k - m_nff - 1 < ncard() + 2) return 8'h5A;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] exp_byte(int i);
    if (m_zf != 0) return (i == 0) ? 8'h00 : pay(i - 1);
    return pay(i);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // card and consumer model, acting on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (armed != 0) begin
        if (lat == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = card_byte(kbyte);
          kbyte++;
          armed = 0;
        end else lat--;
      end
      xchg_ready = (($urandom % 100) < m_xrdy);
      if (xchg_valid && xchg_ready) begin
        xchg_cnt++;
        if (xchg_tx != 8'hFF) bad_tx++;
        armed = 1;
        lat = $urandom % (m_lat + 1);
      end
      if (hold_pend != 0 && (!out_valid || out_data != hd || out_idx != hi)) hold_err++;
      if (out_valid && xchg_valid) gap_err++;
      out_ready = (($urandom % 100) < m_ordy);
      hold_pend = (out_valid && !out_ready) ? 1 : 0;
      hd = out_data;
      hi = out_idx;
      if (out_valid && out_ready) begin
        if (int'(out_idx) != out_cnt || out_data != exp_byte(out_cnt)) data_err++;
        out_cnt++;
      end
      if (done) begin
        done_seen = 1;
        done_stat = status;
      end
    end
  end

  task automatic run_case(int nff, logic [7:0] tok, int len, int zf, int latm,
                          int xr, int orr, int exp_st);
    int exp_x;
    m_nff = nff; m_tok = tok; m_len = len; m_zf = zf; m_lat = latm;
    m_xrdy = xr; m_ordy = orr; pay_base = $urandom % 256;
    kbyte = 0; xchg_cnt = 0; bad_tx = 0; out_cnt = 0; data_err = 0;
    hold_err = 0; gap_err = 0; done_seen = 0;
    @(negedge clk);
    start = 1'b1; blk_len = LW'(len); zero_first = zf[0];
    @(negedge clk);
    start = 1'b0;
    chk("R11 busy after start", int'(busy), 1);
    for (int c = 0; c < 60000 && done_seen == 0; c++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R11 busy low after done", int'(busy), 0);
    if (exp_st == 0) exp_x = nff + 1 + ((zf != 0) ? len - 1 : len) + 2;
    else if (exp_st == 2) exp_x = nff + 1;
    else exp_x = LIMIT;
    chk("R7 done seen", done_seen, 1);
    chk("R4 R5 R7 status", int'(done_stat), exp_st);
    chk("R3 R7 exchange count", xchg_cnt, exp_x);
    chk("R6 R8 byte count", out_cnt, (exp_st == 0) ? len : 0);
    chk("R6 R8 data and index", data_err, 0);
    chk("R2 filler bytes", bad_tx, 0);
    chk("R10 hold while stalled", hold_err, 0);
    chk("R10 no exchange under backpressure", gap_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (finished == 0) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 xchg_valid", int'(xchg_valid), 0);
    chk("R1 out_valid", int'(out_valid), 0);

    // R9 zero length
    xchg_cnt = 0;
    start = 1'b1; blk_len = '0; zero_first = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk("R9 done next cycle", int'(done), 1);
    chk("R9 status ok", int'(status), 0);
    repeat (3) @(negedge clk);
    chk("R9 no exchange", xchg_cnt, 0);

    // directed cases
    run_case(0, 8'hFE, 1, 0, 0, 100, 100, 0);
    run_case(3, 8'hFE, 1, 1, 1, 100, 100, 0);       // R8 length one
    run_case(2, 8'hFE, 16, 1, 2, 60, 40, 0);        // R8
    run_case(5, 8'h05, 8, 0, 1, 80, 80, 2);         // R5
    run_case(0, 8'h00, 8, 1, 0, 100, 100, 2);       // R5
    run_case(7, 8'hFE, 512, 0, 0, 100, 90, 0);      // R6 max length
    run_case(LIMIT - 1, 8'hFE, 4, 0, 0, 100, 100, 0); // R3 token at the bound
    run_case(LIMIT + 50, 8'hFE, 4, 0, 0, 100, 100, 1); // R4 timeout

    // random mix
    for (int c = 0; c < 12; c++) begin
      int nff, len, zf, bad;
      logic [7:0] tok;
      nff = $urandom % 40;
      len = 1 + ($urandom % 64);
      zf  = $urandom % 2;
      bad = (($urandom % 5) == 0) ? 1 : 0;
      tok = (bad != 0) ? 8'($urandom % 254) : 8'hFE;
      run_case(nff, tok, len, zf, $urandom % 3, 50 + ($urandom % 51),
               30 + ($urandom % 71), (bad != 0) ? 2 : 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule